// File: doc/BRIEF.md
# Bus Breakpoint Wait Controller

This block watches the address and control strobes of an 8-bit microprocessor bus with a 16-bit address and a multiplexed memory/I-O space. When a bus cycle matches a programmed condition, it records a snapshot of the address and strobes for indicator lights. It can also hold the processor in a wait state, which gives a hardware breakpoint. The condition is an AND of two parts. The first is an address compare split into four nibble groups, each of which can be switched in or out. The second is an optional group of control-strobe qualifiers, where every selected strobe must be active together.

All bus and configuration inputs pass through a two-flop synchronizer before they are compared, so every term of the condition sees the same sampled bus state. A fresh match is the rising edge of the combined condition. A fresh match loads the snapshot, and when waiting is enabled it pulls the wait output low. The wait output stays low until a one-cycle step pulse arrives. After that it stays released until the condition has dropped and risen again, which means a new qualifying bus cycle. Restricting the compare to the low two nibbles and selecting the I/O-request strobe stops the processor on accesses to one 8-bit port.

Top module: `bus_break_ctrl`

## Requirements
- R1: Address line i must equal bit i of `cmp_pattern` for an enabled group to match: a pattern bit of 1 needs the line high, 0 needs it low.
- R2: `grp_en[g]` enables the compare of `bus_addr[4g+3:4g]`. A group whose enable is clear matches any address value.
- R3: Strobe vector order is bit 0 WR, 1 MREQ, 2 RD, 3 RFSH, 4 IORQ, 5 M1, with the strobe pins active low. With `qual_en` set, the qualifier group matches only when every strobe selected in `qual_sel` is low in the same sample. For example, IORQ plus WR matches only port writes.
- R4: With `qual_en` clear, the strobe levels and `qual_sel` have no effect on the match.
- R5: With all `grp_en` bits clear and `qual_en` clear, the match never fires and `hit` stays 0.
- R6: On each rising edge of the match condition, `snap_addr` and `snap_strb` (active-low strobes, same order as R3) load the sampled address and strobes. They hold those values until the next rising edge.
- R7: `hit` is 1 while the condition holds. An input change that is driven before clock edge k shows on `hit` after edge k+2, which is three registers.
- R8: With `wait_en` set, a fresh match drives `wait_n` low on the same edge that `hit` rises. With `wait_en` clear, `wait_n` is 1 on the edge that follows.
- R9: Once `wait_n` is low, it stays low until `step_pulse` is seen high at a clock edge, which sets it to 1. It goes low again only on a new rising edge of the condition, not while the same match persists.
- R10: Synchronous reset `rst` sets `hit` to 0, `wait_n` to 1, `snap_addr` to 0 and `snap_strb` to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Processor address bus |
| wr_n | input | 1 | Write strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode-fetch cycle marker, active low |
| cmp_pattern | input | 16 | Required level of each address line |
| grp_en | input | 4 | Per-nibble compare enables |
| qual_en | input | 1 | Enables the strobe qualifier group |
| qual_sel | input | 6 | Strobes that must all be active (order of R3) |
| wait_en | input | 1 | Allows a match to stall the processor |
| step_pulse | input | 1 | One-cycle pulse that releases a held wait |
| snap_addr | output | 16 | Address captured at the latest match |
| snap_strb | output | 6 | Active-low strobes captured at the latest match |
| hit | output | 1 | Match condition, registered |
| wait_n | output | 1 | Wait request to the processor, active low |

## Verification
Every one of the sixteen nibble-enable combinations is swept with the qualifier group both on and off. The addresses used match fully, mismatch in exactly one nibble, or mismatch in every nibble. This separates a wrong group mapping from a wrong bit compare, and it shows the strobes being ignored when the qualifier group is off. The strobe patterns set WR, IORQ and RD independently, so a port-write selection can be told apart from a read or from a single strobe. A reference model of the latest rising edge follows the snapshot across the whole sweep. Directed port-breakpoint sequences measure the exact latency and check the hold, the step release and the refusal to re-stall within one cycle. They also cover a near-miss port number and stalling with waiting disabled.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  localparam int STB_N   = 6;
  localparam int STB_WR  = 0;
  localparam int STB_MRQ = 1;
  localparam int STB_RD  = 2;
  localparam int STB_RFS = 3;
  localparam int STB_IOR = 4;
  localparam int STB_M1  = 5;

  typedef logic [STB_N-1:0] strb_t;
endpackage

// File: rtl/bbc_sync.sv
module bbc_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         stage[s] <= RST_VAL;
      else if (s == 0) stage[s] <= d;
      else             stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/bbc_match.sv
module bbc_match
  import bbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GRP_W  = 4,
  localparam int NGRP  = ADDR_W / GRP_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  strb_t             strb_n,
  input  logic [ADDR_W-1:0] pattern,
  input  logic [NGRP-1:0]   grp_en,
  input  logic              qual_en,
  input  strb_t             qual_sel,
  output logic              cond
);
  logic [NGRP-1:0] grp_ok;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_ok[g] = !grp_en[g] ||
                       (addr[g*GRP_W +: GRP_W] == pattern[g*GRP_W +: GRP_W]);
  end

  logic addr_ok, qual_ok, armed;
  always_comb begin
    addr_ok = &grp_ok;
    qual_ok = !qual_en || ((~strb_n & qual_sel) == qual_sel);
    armed   = (|grp_en) || qual_en;
    cond    = armed && addr_ok && qual_ok;
  end
endmodule

// File: rtl/bbc_wait_ctl.sv
module bbc_wait_ctl
  import bbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cond,
  input  logic [ADDR_W-1:0] addr,
  input  strb_t             strb_n,
  input  logic              wait_en,
  input  logic              step_pulse,
  output logic [ADDR_W-1:0] snap_addr,
  output strb_t             snap_strb,
  output logic              hit,
  output logic              wait_n
);
  logic fresh;
  assign fresh = cond && !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= 1'b0;
      snap_addr <= '0;
      snap_strb <= '1;
    end else begin
      hit <= cond;
      if (fresh) begin
        snap_addr <= addr;
        snap_strb <= strb_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     wait_n <= 1'b1;
    else if (!wait_en)           wait_n <= 1'b1;
    else if (!wait_n && step_pulse) wait_n <= 1'b1;
    else if (fresh)              wait_n <= 1'b0;
  end
endmodule

// File: rtl/bus_break_ctrl.sv
module bus_break_ctrl
  import bbc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int GRP_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NGRP       = ADDR_W / GRP_W,
  localparam int SYNC_W     = 2*ADDR_W + NGRP + 1 + 2*STB_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_n,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              rfsh_n,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic [ADDR_W-1:0] cmp_pattern,
  input  logic [NGRP-1:0]   grp_en,
  input  logic              qual_en,
  input  logic [STB_N-1:0]  qual_sel,
  input  logic              wait_en,
  input  logic              step_pulse,
  output logic [ADDR_W-1:0] snap_addr,
  output logic [STB_N-1:0]  snap_strb,
  output logic              hit,
  output logic              wait_n
);
  strb_t strb_raw;
  assign strb_raw = {m1_n, iorq_n, rfsh_n, rd_n, mreq_n, wr_n};

  localparam logic [SYNC_W-1:0] SYNC_RST = {{ADDR_W{1'b0}}, {STB_N{1'b1}},
                                            {ADDR_W{1'b0}}, {NGRP{1'b0}},
                                            1'b0, {STB_N{1'b0}}};

  logic [ADDR_W-1:0] addr_s, pat_s;
  strb_t             strb_s, sel_s;
  logic [NGRP-1:0]   grp_en_s;
  logic              qual_en_s;
  logic              cond;

  bbc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_addr, strb_raw, cmp_pattern, grp_en, qual_en, qual_sel}),
    .q   ({addr_s, strb_s, pat_s, grp_en_s, qual_en_s, sel_s})
  );

  bbc_match #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_match (
    .addr     (addr_s),
    .strb_n   (strb_s),
    .pattern  (pat_s),
    .grp_en   (grp_en_s),
    .qual_en  (qual_en_s),
    .qual_sel (sel_s),
    .cond     (cond)
  );

  bbc_wait_ctl #(.ADDR_W(ADDR_W)) u_wait (
    .clk        (clk),
    .rst        (rst),
    .cond       (cond),
    .addr       (addr_s),
    .strb_n     (strb_s),
    .wait_en    (wait_en),
    .step_pulse (step_pulse),
    .snap_addr  (snap_addr),
    .snap_strb  (snap_strb),
    .hit        (hit),
    .wait_n     (wait_n)
  );
endmodule

// File: rtl/bbc_checker.sv
module bbc_checker #(
  parameter int ADDR_W = 16,
  parameter int NGRP   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wait_en,
  input logic              step_pulse,
  input logic [NGRP-1:0]   grp_en_s,
  input logic              qual_en_s,
  input logic [ADDR_W-1:0] snap_addr,
  input logic [5:0]        snap_strb,
  input logic              hit,
  input logic              wait_n
);
  assert_no_enable_no_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (grp_en_s == '0 && !qual_en_s) |=> !hit);

  assert_snap_addr_held_R6: assert property (@(posedge clk) disable iff (rst)
    !$rose(hit) |-> $stable(snap_addr));

  assert_snap_strb_held_R6: assert property (@(posedge clk) disable iff (rst)
    !$rose(hit) |-> $stable(snap_strb));

  assert_wait_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !wait_en |=> wait_n);

  assert_wait_on_fresh_hit_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_n) |-> $rose(hit));

  assert_wait_held_R9: assert property (@(posedge clk) disable iff (rst)
    (wait_en && !wait_n && !step_pulse) |=> !wait_n);

  assert_step_releases_R9: assert property (@(posedge clk) disable iff (rst)
    (!wait_n && step_pulse) |=> wait_n);
endmodule

bind bus_break_ctrl bbc_checker #(.ADDR_W(ADDR_W), .NGRP(NGRP)) u_bbc_checker (
  .clk        (clk),
  .rst        (rst),
  .wait_en    (wait_en),
  .step_pulse (step_pulse),
  .grp_en_s   (grp_en_s),
  .qual_en_s  (qual_en_s),
  .snap_addr  (snap_addr),
  .snap_strb  (snap_strb),
  .hit        (hit),
  .wait_n     (wait_n)
);

// File: tb/tb_bus_break_ctrl.sv
module tb_bus_break_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic [5:0]  strb;       // {m1,iorq,rfsh,rd,mreq,wr}, active low
  logic [15:0] cmp_pattern;
  logic [3:0]  grp_en;
  logic        qual_en;
  logic [5:0]  qual_sel;
  logic        wait_en;
  logic        step_pulse;
  logic [15:0] snap_addr;
  logic [5:0]  snap_strb;
  logic        hit;
  logic        wait_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_break_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr),
    .wr_n(strb[0]), .mreq_n(strb[1]), .rd_n(strb[2]),
    .rfsh_n(strb[3]), .iorq_n(strb[4]), .m1_n(strb[5]),
    .cmp_pattern(cmp_pattern), .grp_en(grp_en), .qual_en(qual_en),
    .qual_sel(qual_sel), .wait_en(wait_en), .step_pulse(step_pulse),
    .snap_addr(snap_addr), .snap_strb(snap_strb), .hit(hit), .wait_n(wait_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit model(input logic [15:0] a, input logic [5:0] s,
                               input logic [15:0] p, input logic [3:0] ge,
                               input logic qe, input logic [5:0] sel);
    bit ok = (ge != 0) || qe;
    for (int g = 0; g < 4; g++)
      if (ge[g] && (((a >> (4*g)) & 16'hF) != ((p >> (4*g)) & 16'hF))) ok = 0;
    if (qe && ((~s & sel) != sel)) ok = 0;
    return ok;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] exp_sa;
    logic [5:0]  exp_ss;
    bit prev;
    rst = 1; bus_addr = 0; strb = '1; cmp_pattern = 0; grp_en = 0;
    qual_en = 0; qual_sel = 0; wait_en = 0; step_pulse = 0;
    tick(3);
    rst = 0;
    tick(1);
    // R10 reset state
    check("R10 hit", hit, 0);
    check("R10 wait_n", wait_n, 1);
    check("R10 snap_addr", snap_addr, 0);
    check("R10 snap_strb", snap_strb, 6'h3F);

    // Sweep: R1 R2 R3 R4 R5 R6 R7 R8 (wait_en clear)
    cmp_pattern = 16'hA5C3;
    qual_sel = 6'b010001;       // IORQ and WR
    exp_sa = 0; exp_ss = 6'h3F; prev = 0;
    for (int ge = 0; ge < 16; ge++) begin
      for (int qe = 0; qe < 2; qe++) begin
        for (int j = 0; j < 8; j++) begin
          for (int k = 0; k < 8; k++) begin
            logic [15:0] a;
            logic [5:0]  s;
            bit e;
            if (j < 4)       a = cmp_pattern ^ (16'h1 << (4*j));
            else if (j == 5) a = ~cmp_pattern;
            else if (j == 6) a = cmp_pattern ^ 16'h8001;
            else             a = cmp_pattern;
            s = ~{1'b0, k[1], 1'b0, k[2], 1'b0, k[0]};
            grp_en = 4'(ge); qual_en = qe[0]; bus_addr = a; strb = s;
            e = model(a, s, cmp_pattern, 4'(ge), qe[0], qual_sel);
            if (e && !prev) begin exp_sa = a; exp_ss = s; end
            prev = e;
            tick(3);
            if (ge == 0 && qe == 0) check("R5 no enable", hit, 0);
            else if (qe == 0)       check("R4/R2/R1 hit", hit, e);
            else                    check("R3/R2/R1 hit", hit, e);
            check("R6 snap_addr", snap_addr, exp_sa);
            check("R6 snap_strb", snap_strb, exp_ss);
            check("R8 wait_n with wait_en clear", wait_n, 1);
          end
        end
      end
    end

    // Directed port breakpoint: port 0xFA, IORQ, wait enabled
    bus_addr = 16'h1200; strb = '1;
    cmp_pattern = 16'h00FA; grp_en = 4'b0011; qual_en = 1;
    qual_sel = 6'b010000; wait_en = 1;
    tick(4);
    check("R8 idle wait_n", wait_n, 1);
    bus_addr = 16'h12FA; strb = 6'b101111;   // IORQ low
    tick(2);
    check("R7 hit not yet", hit, 0);
    check("R8 wait not yet", wait_n, 1);
    tick(1);
    check("R7 hit latency", hit, 1);
    check("R8 wait asserted", wait_n, 0);
    check("R6 snap port", snap_addr, 16'h12FA);
    tick(5);
    check("R9 wait held", wait_n, 0);
    step_pulse = 1;
    tick(1);
    step_pulse = 0;
    check("R9 step release", wait_n, 1);
    tick(4);
    check("R9 no restall same cycle", wait_n, 1);
    check("R7 hit still high", hit, 1);
    strb = '1;
    tick(4);
    check("R7 hit drops", hit, 0);
    check("R9 stays released", wait_n, 1);
    bus_addr = 16'h34FA; strb = 6'b101111;
    tick(3);
    check("R9 restall on new cycle", wait_n, 0);
    check("R6 snap new cycle", snap_addr, 16'h34FA);
    wait_en = 0;
    tick(1);
    check("R8 wait_en dropped", wait_n, 1);
    strb = '1; tick(4);

    // Near-miss port 0xFB must not stall
    wait_en = 1;
    bus_addr = 16'h00FB; strb = 6'b101111;
    tick(4);
    check("R1 near miss no wait", wait_n, 1);
    check("R1 near miss no hit", hit, 0);
    strb = '1; tick(4);

    // Port write only: IORQ+WR selected, a port read is refused
    qual_sel = 6'b010001;
    bus_addr = 16'h00FA; strb = 6'b101011;   // IORQ+RD
    tick(4);
    check("R3 port read ignored", wait_n, 1);
    strb = '1; tick(4);
    strb = 6'b101110;                        // IORQ+WR
    tick(4);
    check("R3 port write stalls", wait_n, 0);
    check("R6 snap strobes", snap_strb, 6'b101110);
    step_pulse = 1; tick(1); step_pulse = 0;
    check("R9 release after write", wait_n, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule